// File: doc/BRIEF.md
# ECC Configuration and Error Status Register File

This block is the software-visible control point for error-correcting-code protection on five memories: instruction memory, data memory, instruction cache, data cache and translation buffer. A simple register port lets software enable checking and exception reporting for each memory separately. Software can also make a memory store a programmed check code instead of the computed one, so that faults can be injected on purpose. Each memory drives two single-cycle pulses into the block, one for a corrected single-bit error and one for a detected double-bit error. The block keeps a sticky flag for each pulse, and software clears a flag by writing a one to it.

A small lock state machine guards the configuration. It has two states. `LK_OPEN` is entered at reset and allows writes. `LK_SEALED` freezes every register. The only transition goes from `LK_OPEN` to `LK_SEALED` and is taken on a write to the lock register with bit 0 set. `LK_SEALED` holds until reset, and no other transition exists. Error pulses still update the sticky flags in `LK_SEALED`, so hardware reporting continues after the configuration is sealed.

Reads are combinational: data and the illegal-access flag are valid in the same cycle as the request. Writes take effect at the next rising clock edge.

Top module: `ecc_csr_regs`

## Requirements
- R1: After reset, all enable, exception-enable and injection-select outputs are 0, the injection code is 0, every status flag is 0 and the block is unlocked. Every mapped register therefore reads 0.
- R2: The per-memory control registers sit at 0x7C0 (instruction memory), 0x7C1 (data memory) and 0x7DD (translation buffer). In each of these registers bit 0 is the ECC enable, bit 1 is the exception enable and bit 2 is the injection select. Register 0x7CA holds the instruction cache fields in bits 2:0 and the data cache fields in bits 6:4, in the same order. A write sets the fields, and the register reads back the same values that drive the outputs.
- R3: Register 0x7C2 holds the injection code in its low CODE_W bits and drives `inj_code`. Its upper bits read 0.
- R4: A pulse on `err_single[i]` sets the correctable flag of memory i, at bit 8 of its register (bit 12 for the data cache). The flag stays set until it is cleared.
- R5: A pulse on `err_double[i]` sets the uncorrectable flag of memory i, at bit 9 (bit 13 for the data cache). This flag is separate from the correctable flag and is equally sticky.
- R6: Writing 1 to a status flag clears it. Writing 0 leaves it unchanged.
- R7: When an error pulse arrives in the same cycle as a write that clears the same flag, the flag stays set.
- R8: Bit 0 of register 0x7DE is the lock. Writing 1 sets it, writing 0 has no effect, and the register reads the current lock state.
- R9: While locked, writes to every register listed in R2, R3, R6 and R8 are ignored until reset, including status clears. Error pulses still set status flags.
- R10: An access to any address outside the six mapped ones raises `csr_illegal` in the same cycle and reads 0. Mapped addresses never raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_req | input | 1 | Register access request |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Read data, combinational |
| csr_illegal | output | 1 | Access to an unmapped address |
| err_single | input | 5 | Per-memory single-bit error pulses |
| err_double | input | 5 | Per-memory double-bit error pulses |
| ecc_en | output | 5 | Per-memory ECC enable |
| exc_en | output | 5 | Per-memory exception enable |
| inj_sel | output | 5 | Per-memory injected-code select |
| inj_code | output | CODE_W | Shared injection check code |

## Verification
The assertions check the following on every cycle. An error pulse always leaves its flag set in the next cycle, even when a clear arrives with it. A set flag stays set unless it is explicitly cleared. The lock state never leaves `LK_SEALED`. While locked, no output changes. An illegal access always reads 0. The field layout, the decoding of all addresses near the mapped range, the full range of injection codes, and the fact that reset is the only way back to `LK_OPEN` cannot be shown by assertions. Only the bench sweeps can show them, by comparing read-back values with values the bench computes itself.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;

    localparam int NMEM    = 5;
    localparam int CSR_AW  = 12;
    localparam int CFG_W   = 3;
    localparam int STS_W   = 2;
    localparam int STS_OFS = 8;

    localparam int IDX_IMEM   = 0;
    localparam int IDX_DMEM   = 1;
    localparam int IDX_ICACHE = 2;
    localparam int IDX_DCACHE = 3;
    localparam int IDX_TLB    = 4;

    localparam logic [CSR_AW-1:0] ADR_IMEM  = 12'h7C0;
    localparam logic [CSR_AW-1:0] ADR_DMEM  = 12'h7C1;
    localparam logic [CSR_AW-1:0] ADR_CODE  = 12'h7C2;
    localparam logic [CSR_AW-1:0] ADR_CACHE = 12'h7CA;
    localparam logic [CSR_AW-1:0] ADR_TLB   = 12'h7DD;
    localparam logic [CSR_AW-1:0] ADR_LOCK  = 12'h7DE;

    typedef enum logic {LK_OPEN, LK_SEALED} lock_state_e;

    function automatic logic [CSR_AW-1:0] slot_addr(input int idx);
        case (idx)
            IDX_IMEM:   return ADR_IMEM;
            IDX_DMEM:   return ADR_DMEM;
            IDX_ICACHE: return ADR_CACHE;
            IDX_DCACHE: return ADR_CACHE;
            default:    return ADR_TLB;
        endcase
    endfunction

    function automatic int slot_shift(input int idx);
        return (idx == IDX_DCACHE) ? 4 : 0;
    endfunction

endpackage

// File: rtl/ecc_csr_decode.sv
module ecc_csr_decode
    import ecc_csr_pkg::*;
(
    input  logic              req,
    input  logic [CSR_AW-1:0] addr,
    output logic [NMEM-1:0]   slot_hit,
    output logic              code_hit,
    output logic              lock_hit,
    output logic              illegal
);
    for (genvar g = 0; g < NMEM; g++) begin : g_hit
        assign slot_hit[g] = req && (addr == slot_addr(g));
    end

    assign code_hit = req && (addr == ADR_CODE);
    assign lock_hit = req && (addr == ADR_LOCK);
    assign illegal  = req && !(|slot_hit) && !code_hit && !lock_hit;
endmodule

// File: rtl/ecc_lock_fsm.sv
module ecc_lock_fsm
    import ecc_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seal_req,
    output logic locked
);
    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (seal_req) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LK_OPEN:   locked = 1'b0;
            LK_SEALED: locked = 1'b1;
        endcase
    end

    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    assert_lock_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seal_req |=> locked);
endmodule

// File: rtl/ecc_mem_slot.sv
module ecc_mem_slot
    import ecc_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_cfg,
    input  logic [STS_W-1:0] wr_clr,
    input  logic             err_single,
    input  logic             err_double,
    output logic [CFG_W-1:0] cfg,
    output logic [STS_W-1:0] sts
);
    logic [STS_W-1:0] clr_mask;
    logic [STS_W-1:0] sts_d;

    assign clr_mask = wr_en ? wr_clr : '0;
    assign sts_d    = (sts & ~clr_mask) | {err_double, err_single};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
            sts <= '0;
        end else begin
            if (wr_en) cfg <= wr_cfg;
            sts <= sts_d;
        end
    end

    assert_corr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_single |=> sts[0]);
    assert_uncorr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_double |=> sts[1]);
    assert_corr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[0] && !(wr_en && wr_clr[0])) |=> sts[0]);
    assert_uncorr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[1] && !(wr_en && wr_clr[1])) |=> sts[1]);
    assert_err_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_double && wr_en && wr_clr[1]) |=> sts[1]);
endmodule

// File: rtl/ecc_csr_regs.sv
module ecc_csr_regs
    import ecc_csr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_req,
    input  logic              csr_we,
    input  logic [11:0]       csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              csr_illegal,
    input  logic [4:0]        err_single,
    input  logic [4:0]        err_double,
    output logic [4:0]        ecc_en,
    output logic [4:0]        exc_en,
    output logic [4:0]        inj_sel,
    output logic [CODE_W-1:0] inj_code
);
    localparam int TOP_FIELD = STS_OFS + 4 + STS_W;

    logic [NMEM-1:0]             slot_hit;
    logic                        code_hit;
    logic                        lock_hit;
    logic                        locked;
    logic                        wr_ok;
    logic [NMEM-1:0][CFG_W-1:0]  cfg_a;
    logic [NMEM-1:0][STS_W-1:0]  sts_a;
    logic                        unused_wdata;

    assign unused_wdata = ^csr_wdata;

    ecc_csr_decode u_dec (
        .req      (csr_req),
        .addr     (csr_addr),
        .slot_hit (slot_hit),
        .code_hit (code_hit),
        .lock_hit (lock_hit),
        .illegal  (csr_illegal)
    );

    ecc_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .seal_req (lock_hit && csr_we && csr_wdata[0]),
        .locked   (locked)
    );

    assign wr_ok = csr_we && !locked;

    for (genvar g = 0; g < NMEM; g++) begin : g_slot
        localparam int SH = slot_shift(g);
        ecc_mem_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_ok && slot_hit[g]),
            .wr_cfg     (csr_wdata[SH +: CFG_W]),
            .wr_clr     (csr_wdata[SH + STS_OFS +: STS_W]),
            .err_single (err_single[g]),
            .err_double (err_double[g]),
            .cfg        (cfg_a[g]),
            .sts        (sts_a[g])
        );
        assign ecc_en[g]  = cfg_a[g][0];
        assign exc_en[g]  = cfg_a[g][1];
        assign inj_sel[g] = cfg_a[g][2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 inj_code <= '0;
        else if (wr_ok && code_hit) inj_code <= csr_wdata[CODE_W-1:0];
    end

    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < NMEM; i++) begin
            if (slot_hit[i]) begin
                csr_rdata = csr_rdata
                          | (DATA_W'(cfg_a[i]) << slot_shift(i))
                          | (DATA_W'(sts_a[i]) << (slot_shift(i) + STS_OFS));
            end
        end
        if (code_hit) csr_rdata = DATA_W'(inj_code);
        if (lock_hit) csr_rdata = DATA_W'(locked);
    end

    initial begin
        assert (DATA_W >= TOP_FIELD && CODE_W <= DATA_W && CODE_W > 0)
            else $error("ecc_csr_regs: register width too small");
    end

    assert_frozen_when_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable({ecc_en, exc_en, inj_sel, inj_code}));
    assert_illegal_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == '0));
endmodule

// File: tb/ecc_csr_regs_test.sv
`timescale 1ns/1ps
module ecc_csr_regs_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        csr_req, csr_we;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata, csr_rdata;
    logic        csr_illegal;
    logic [4:0]  err_single, err_double, ecc_en, exc_en, inj_sel;
    logic [7:0]  inj_code;

    always #2 clk = ~clk;

    ecc_csr_regs uut (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .err_single(err_single), .err_double(err_double),
        .ecc_en(ecc_en), .exc_en(exc_en), .inj_sel(inj_sel), .inj_code(inj_code)
    );

    int checks = 0;
    int errors = 0;
    logic [2:0] m_cfg [5];
    logic [1:0] m_sts [5];
    logic [7:0] m_code;
    logic       m_lock;

    function automatic int sh(int i);
        return (i == 3) ? 4 : 0;
    endfunction

    function automatic logic [11:0] ad(int i);
        case (i)
            0: return 12'h7C0;
            1: return 12'h7C1;
            2, 3: return 12'h7CA;
            default: return 12'h7DD;
        endcase
    endfunction

    function automatic bit mapped(logic [11:0] a);
        return a == 12'h7C0 || a == 12'h7C1 || a == 12'h7C2 ||
               a == 12'h7CA || a == 12'h7DD || a == 12'h7DE;
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        logic [31:0] r = '0;
        for (int i = 0; i < 5; i++)
            if (ad(i) == a)
                r = r | (32'(m_cfg[i]) << sh(i)) | (32'(m_sts[i]) << (sh(i) + 8));
        if (a == 12'h7C2) r = 32'(m_code);
        if (a == 12'h7DE) r = 32'(m_lock);
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outs(string req);
        logic [4:0] e, x, s;
        for (int i = 0; i < 5; i++) begin
            e[i] = m_cfg[i][0]; x[i] = m_cfg[i][1]; s[i] = m_cfg[i][2];
        end
        check(req, {9'b0, ecc_en, exc_en, inj_sel, inj_code}, {9'b0, e, x, s, m_code});
    endtask

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin m_cfg[i] = '0; m_sts[i] = '0; end
        m_code = '0; m_lock = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; csr_req = 0; csr_we = 0; csr_addr = '0; csr_wdata = '0;
        err_single = '0; err_double = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // one cycle: optional write plus error pulses
    task automatic cyc(bit we, logic [11:0] a, logic [31:0] d, logic [4:0] sg, logic [4:0] db);
        @(negedge clk);
        csr_req = we; csr_we = we; csr_addr = a; csr_wdata = d;
        err_single = sg; err_double = db;
        if (we && !m_lock) begin
            for (int i = 0; i < 5; i++)
                if (ad(i) == a) begin
                    m_cfg[i] = d[sh(i) +: 3];
                    m_sts[i] = m_sts[i] & ~d[sh(i) + 8 +: 2];
                end
            if (a == 12'h7C2) m_code = d[7:0];
            if (a == 12'h7DE && d[0]) m_lock = 1'b1;
        end
        for (int i = 0; i < 5; i++) m_sts[i] = m_sts[i] | {db[i], sg[i]};
        @(negedge clk);
        csr_req = 0; csr_we = 0; err_single = '0; err_double = '0;
    endtask

    task automatic rd(logic [11:0] a, string req);
        @(negedge clk);
        csr_req = 1; csr_we = 0; csr_addr = a;
        #1;
        check(req, csr_rdata, exp_read(a));
        check({req, " illegal"}, 32'(csr_illegal), 32'(!mapped(a)));
        check_outs(req);
        csr_req = 0;
    endtask

    task automatic read_all(string req);
        rd(12'h7C0, req); rd(12'h7C1, req); rd(12'h7C2, req);
        rd(12'h7CA, req); rd(12'h7DD, req); rd(12'h7DE, req);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        read_all("R1 reset state");

        // R10: sweep around the mapped window and a few far addresses
        for (int a = 12'h7B8; a <= 12'h7E7; a++) rd(12'(a), "R10 decode sweep");
        rd(12'h000, "R10 low"); rd(12'hFC0, "R10 high"); rd(12'hFFF, "R10 top");
        cyc(1, 12'h7C3, 32'hFFFF_FFFF, '0, '0);
        read_all("R10 unmapped write no effect");

        // R2: every field pattern on every control register
        for (int p = 0; p < 8; p++) begin
            cyc(1, 12'h7C0, 32'(p), '0, '0);
            cyc(1, 12'h7C1, 32'(7 - p), '0, '0);
            cyc(1, 12'h7CA, 32'(p) | (32'(7 - p) << 4), '0, '0);
            cyc(1, 12'h7DD, 32'(p) | 32'hFFFF_0088, '0, '0);
            read_all("R2 field sweep");
        end

        // R3: full code range with noise in the upper bits
        for (int v = 0; v < 256; v++) begin
            cyc(1, 12'h7C2, 32'hA5A5_A500 | 32'(v), '0, '0);
            rd(12'h7C2, "R3 code sweep");
        end

        // R4/R5: per-memory pulses, sticky after idle cycles
        for (int i = 0; i < 5; i++) begin
            cyc(0, '0, '0, 5'(1 << i), '0);
            repeat (3) @(negedge clk);
            rd(ad(i), "R4 corr sticky");
            cyc(0, '0, '0, '0, 5'(1 << i));
            rd(ad(i), "R5 uncorr separate");
        end
        read_all("R4 R5 all set");

        // R6: zero writes keep, one writes clear
        for (int i = 0; i < 5; i++) begin
            cyc(1, ad(i), 32'(3'd5) << sh(i), '0, '0);
            rd(ad(i), "R6 zero keeps");
            cyc(1, ad(i), (32'(3'd5) << sh(i)) | (32'h1 << (sh(i) + 8)), '0, '0);
            rd(ad(i), "R6 clear corr");
            cyc(1, ad(i), 32'h3 << (sh(i) + 8), '0, '0);
            rd(ad(i), "R6 clear uncorr");
        end

        // R7: pulse beats a simultaneous clear
        cyc(1, 12'h7C1, 32'h0000_0300, 5'b00010, 5'b00000);
        rd(12'h7C1, "R7 corr wins");
        cyc(1, 12'h7CA, 32'h0000_3000, 5'b00000, 5'b01000);
        rd(12'h7CA, "R7 uncorr wins");

        // R8: zero write does not lock, one write does
        cyc(1, 12'h7DE, 32'hFFFF_FFFE, '0, '0);
        rd(12'h7DE, "R8 zero no lock");
        cyc(1, 12'h7C0, 32'h7, '0, '0);
        cyc(1, 12'h7C2, 32'h3C, '0, '0);
        cyc(1, 12'h7DE, 32'h1, '0, '0);
        rd(12'h7DE, "R8 locked");

        // R9: everything frozen, pulses still land
        cyc(1, 12'h7C0, 32'h0000_0300, '0, '0);
        cyc(1, 12'h7C1, 32'h0000_0305, '0, '0);
        cyc(1, 12'h7CA, 32'h0000_3377, '0, '0);
        cyc(1, 12'h7DD, 32'h0000_0306, '0, '0);
        cyc(1, 12'h7C2, 32'h0000_00C3, '0, '0);
        cyc(1, 12'h7DE, 32'h0, '0, '0);
        read_all("R9 writes ignored");
        cyc(0, '0, '0, 5'b10101, 5'b01010);
        read_all("R9 pulses while locked");
        cyc(1, 12'h7CA, 32'h0000_3300, '0, '0);
        rd(12'h7CA, "R9 clear ignored");

        // reset is the only unlock
        do_reset();
        read_all("R1 R9 reset unlocks");
        cyc(1, 12'h7C0, 32'h3, '0, '0);
        rd(12'h7C0, "R9 writable after reset");

        summary();
        $finish;
    end
endmodule